// File: doc/BRIEF.md
# Dual-Form 16-bit Pseudo-Random Sequence Generator

This block produces a pseudo-random bit stream and a 16-bit pseudo-random word from a maximal-length shift register built on the primitive polynomial x^16+x^14+x^13+x^11+1. A static form-select input chooses, per clock, between the external-XOR form and the internal-XOR form. In the external-XOR form one feedback bit is made from several taps. In the internal-XOR form the bit shifted out toggles several positions. The two forms emit the same kind of maximal-length stream, but their register contents differ.

The generator starts from a default seed after a synchronous reset. Software-free control is by a seed-load strobe carrying a 16-bit seed, and an enable that advances the register by one step. The block measures its own period. It counts enabled steps since the last seed load, reset or wrap. When the register comes back to the loaded seed, it latches that count into a 17-bit period output and raises a one-cycle done pulse. A seed of zero would lock the register up, so such a load is refused and flagged.

Top module: `prng16_dual`

## Requirements
- R1: After a synchronous reset the state is 0xACE1, the seed reference is 0xACE1, periodCount is 0, periodDone is 0 and seedError is 0.
- R2: With galoisMode=0 an enabled step computes f = s[0]^s[2]^s[3]^s[5] (bit 0 = LSB) and sets the state to {f, s[15:1]}.
- R3: With galoisMode=1 an enabled step shifts the state right by one and, if the bit shifted out (old s[0]) was 1, XORs the result with 0xB400.
- R4: serialBit always equals state[0], i.e. the bit that the next step shifts out.
- R5: With enable=0 and seedLoad=0 the state does not change.
- R6: seedLoad=1 with a non-zero seedValue loads the state and the seed reference with seedValue and clears the step counter, taking priority over enable.
- R7: seedLoad=1 with seedValue=0 leaves the state unchanged, performs no step, and sets seedError, which stays 1 until reset.
- R8: When an enabled step brings the state back to the seed reference, periodDone is 1 for exactly that one cycle, periodCount shows the number of steps since the last load, reset or wrap, and the counter restarts; for a run in one form this count is 65535.
- R9: A change of galoisMode alone leaves the state unchanged; the new form applies from the next enabled step.
- R10: The state is never all-zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the register by one step |
| seedLoad | input | 1 | Request to load seedValue |
| seedValue | input | 16 | Seed to load; zero is refused |
| galoisMode | input | 1 | 0 = external-XOR form, 1 = internal-XOR form |
| serialBit | output | 1 | Output bit of the stream (state LSB) |
| state | output | 16 | Current register contents |
| periodDone | output | 1 | One-cycle pulse on return to the seed |
| periodCount | output | 17 | Latched count of steps for the last completed period |
| seedError | output | 1 | Sticky flag for a refused zero seed |

## Verification
The hardest condition to reach from the ports is the period wrap. It needs 65535 consecutive enabled steps without interruption, and it must be shown in each form. The stimulus loads a seed and then holds enable high, first in the internal-XOR form and later in the external-XOR form with a different seed, until the done pulse appears. Meanwhile a behavioural model tracks the step count and checks that the pulse comes at exactly step 65535. Form switches while idle, a zero seed with enable high, and a load that overlaps enable are placed between these long runs.

// File: rtl/prng16_pkg.sv
package prng16_pkg;
  typedef struct packed {
    logic loadSeed;
    logic step;
    logic latchPeriod;
  } prngStrobes_t;
endpackage

// File: rtl/prng16_datapath.sv
module prng16_datapath
  import prng16_pkg::*;
#(
  parameter int          WIDTH      = 16,
  parameter logic [15:0] FIB_TAPS   = 16'h002D,
  parameter logic [15:0] GAL_TOGGLE = 16'hB400,
  parameter logic [15:0] INIT_SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  prngStrobes_t     strobes,
  input  logic [WIDTH-1:0] seedValue,
  input  logic             galoisMode,
  output logic [WIDTH-1:0] state,
  output logic             wrapNext,
  output logic [WIDTH:0]   periodCount
);
  localparam int CW = WIDTH + 1;

  logic [WIDTH-1:0] seedRef;
  logic [CW-1:0]    stepCount;
  logic [WIDTH-1:0] nextFib;
  logic [WIDTH-1:0] nextGal;
  logic [WIDTH-1:0] nextState;
  logic             fibFeed;

  assign fibFeed = ^(state & FIB_TAPS[WIDTH-1:0]);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bits
      if (i == WIDTH - 1) begin : g_top
        assign nextFib[i] = fibFeed;
        assign nextGal[i] = GAL_TOGGLE[i] & state[0];
      end else begin : g_mid
        assign nextFib[i] = state[i+1];
        assign nextGal[i] = state[i+1] ^ (GAL_TOGGLE[i] & state[0]);
      end
    end
  endgenerate

  assign nextState = galoisMode ? nextGal : nextFib;
  assign wrapNext  = (nextState == seedRef);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= INIT_SEED[WIDTH-1:0];
      seedRef     <= INIT_SEED[WIDTH-1:0];
      stepCount   <= '0;
      periodCount <= '0;
    end else if (strobes.loadSeed) begin
      state     <= seedValue;
      seedRef   <= seedValue;
      stepCount <= '0;
    end else if (strobes.step) begin
      state <= nextState;
      if (strobes.latchPeriod) begin
        periodCount <= stepCount + 1'b1;
        stepCount   <= '0;
      end else begin
        stepCount <= stepCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prng16_control.sv
module prng16_control
  import prng16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedValue,
  input  logic             wrapNext,
  output prngStrobes_t     strobes,
  output logic             periodDone,
  output logic             seedError
);
  logic seedIsZero;

  assign seedIsZero          = (seedValue == '0);
  assign strobes.loadSeed    = seedLoad && !seedIsZero;
  assign strobes.step        = enable && !seedLoad;
  assign strobes.latchPeriod = enable && !seedLoad && wrapNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      periodDone <= 1'b0;
      seedError  <= 1'b0;
    end else begin
      periodDone <= strobes.latchPeriod;
      if (seedLoad && seedIsZero) seedError <= 1'b1;
    end
  end
endmodule

// File: rtl/prng16_dual.sv
module prng16_dual
  import prng16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedValue,
  input  logic             galoisMode,
  output logic             serialBit,
  output logic [WIDTH-1:0] state,
  output logic             periodDone,
  output logic [WIDTH:0]   periodCount,
  output logic             seedError
);
  prngStrobes_t strobes;
  logic         wrapNext;

  prng16_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad),
    .seedValue(seedValue), .wrapNext(wrapNext), .strobes(strobes),
    .periodDone(periodDone), .seedError(seedError)
  );

  prng16_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .seedValue(seedValue),
    .galoisMode(galoisMode), .state(state), .wrapNext(wrapNext),
    .periodCount(periodCount)
  );

  assign serialBit = state[0];
endmodule

// File: rtl/prng16_checker.sv
module prng16_checker (
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic        seedLoad,
  input logic [15:0] seedValue,
  input logic        galoisMode,
  input logic        serialBit,
  input logic [15:0] state,
  input logic        periodDone,
  input logic [16:0] periodCount,
  input logic        seedError
);
  assert_never_zero_R10: assert property (@(posedge clk) disable iff (rst)
    state != 16'h0000);

  assert_serial_lsb_R4: assert property (@(posedge clk) disable iff (rst)
    serialBit == state[0]);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!enable && !seedLoad) |=> $stable(state));

  assert_fib_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (enable && !seedLoad && !galoisMode) |=> state[14:0] == $past(state[15:1]));

  assert_gal_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && !seedLoad && galoisMode) |=>
      ((state ^ ($past(state) >> 1)) == 16'h0000) ||
      ((state ^ ($past(state) >> 1)) == 16'hB400));

  assert_zero_seed_R7: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedValue == 16'h0000) |=> (seedError && $stable(state)));

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    seedError |=> seedError);

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedValue != 16'h0000) |=> state == $past(seedValue));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    periodDone |=> !periodDone);

  assert_done_count_R8: assert property (@(posedge clk) disable iff (rst)
    periodDone |-> periodCount != 17'd0);
endmodule

bind prng16_dual prng16_checker i_chk (
  .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad),
  .seedValue(seedValue), .galoisMode(galoisMode), .serialBit(serialBit),
  .state(state), .periodDone(periodDone), .periodCount(periodCount),
  .seedError(seedError)
);

// File: tb/test_prng16_dual.sv
module test_prng16_dual;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        seedLoad = 1'b0;
  logic [15:0] seedValue = 16'h0000;
  logic        galoisMode = 1'b0;
  logic        serialBit;
  logic [15:0] state;
  logic        periodDone;
  logic [16:0] periodCount;
  logic        seedError;

  int checkCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit finished = 0;

  logic [15:0] refState, refSeed;
  int          refCnt, refPer;
  bit          refDone, refErr;

  prng16_dual i_prng16_dual (
    .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad),
    .seedValue(seedValue), .galoisMode(galoisMode), .serialBit(serialBit),
    .state(state), .periodDone(periodDone), .periodCount(periodCount),
    .seedError(seedError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] stepFib(logic [15:0] s);
    int taps[4] = '{0, 2, 3, 5};
    int fb = 0;
    foreach (taps[k]) fb = fb ^ int'(s[taps[k]]);
    return (s >> 1) | (16'(fb) << 15);
  endfunction

  function automatic logic [15:0] stepGal(logic [15:0] s);
    if (s % 2 == 1) return (s >> 1) ^ 16'hB400;
    return s >> 1;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(galoisMode ? "R3" : "R2", "state", state, refState);
    check("R4", "serialBit", serialBit, refState[0]);
    check("R8", "periodDone", periodDone, refDone);
    check("R8", "periodCount", periodCount, refPer);
    check("R7", "seedError", seedError, refErr);
  endtask

  task automatic tick(bit r, bit en, bit ld, logic [15:0] val, bit gm);
    rst = r; enable = en; seedLoad = ld; seedValue = val; galoisMode = gm;
    @(posedge clk);
    refDone = 0;
    if (r) begin
      refState = 16'hACE1; refSeed = 16'hACE1; refCnt = 0; refPer = 0; refErr = 0;
    end else if (ld && val != 0) begin
      refState = val; refSeed = val; refCnt = 0;
    end else if (ld) begin
      refErr = 1;
    end else if (en) begin
      refState = gm ? stepGal(refState) : stepFib(refState);
      refCnt++;
      if (refState == refSeed) begin
        refPer = refCnt; refCnt = 0; refDone = 1;
      end
    end
    #(CLK_PERIOD/4);
    compareAll();
  endtask

  task automatic fullPeriod(string req, bit gm);
    int steps = 0;
    bit seen = 0;
    while (!seen && steps < 70000) begin
      tick(0, 1, 0, 16'h0, gm);
      steps++;
      seen = periodDone;
    end
    check(req, "steps to wrap", steps, 65535);
    check(req, "latched period", periodCount, 65535);
    tick(0, 0, 0, 16'h0, gm);
    check(req, "done falls", periodDone, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      failCount++;
      checkCount++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    @(negedge clk);
    for (int k = 0; k < 3; k++) tick(1, 0, 0, 16'h0, 0);
    // R1: reset state
    check("R1", "reset state", state, 16'hACE1);
    check("R1", "reset period", periodCount, 0);
    check("R1", "reset error", seedError, 0);
    // R3: internal-XOR steps
    for (int k = 0; k < 20; k++) tick(0, 1, 0, 16'h0, 1);
    // R5, R9: idle with form toggles
    held = state;
    for (int k = 0; k < 6; k++) tick(0, 0, 0, 16'h0, k[0]);
    check("R9", "state after form toggles", state, held);
    check("R5", "state held idle", state, held);
    // R2: external-XOR steps, R9 new form used at next step
    for (int k = 0; k < 20; k++) tick(0, 1, 0, 16'h0, 0);
    // R6: load with enable high
    tick(0, 1, 1, 16'h1234, 1);
    check("R6", "loaded seed", state, 16'h1234);
    // R7: zero seed refused with enable high
    held = state;
    tick(0, 1, 1, 16'h0000, 1);
    check("R7", "state kept on zero seed", state, held);
    check("R7", "error set", seedError, 1);
    for (int k = 0; k < 5; k++) tick(0, 1, 0, 16'h0, 1);
    check("R7", "error sticky", seedError, 1);
    // R8: full period internal-XOR from 0x1234 (counter restarted by load)
    tick(0, 0, 1, 16'h1234, 1);
    fullPeriod("R8", 1);
    check("R10", "nonzero", state != 0, 1);
    // R8: full period external-XOR from 0xACE1
    tick(0, 0, 1, 16'hACE1, 0);
    fullPeriod("R8", 0);
    // R1: reset clears error
    tick(1, 0, 0, 16'h0, 0);
    check("R1", "error cleared", seedError, 0);
    check("R1", "state after reset", state, 16'hACE1);
    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule